// File: doc/BRIEF.md
# Exception Entry and Register-Window Controller

This block keeps the processor's status word and its saved copy, and it sequences every entry into and return from an exception handler. The status word holds four condition flags, the current window pointer, an interrupt-enable bit and a 6-bit priority field. Exceptions come from three sources: an external request that carries a 6-bit number, a software trap instruction that carries a 6-bit immediate, and a register window that runs past its programmable bounds on save or restore. When an exception is taken, the block reports the vector index for the handler and the value to write into the link register. It also moves the window pointer by one step and snapshots the status word.

The instruction pipeline presents one operation code per cycle on `op_i`, together with the address of that instruction. The block makes all of its decisions combinationally from the current state and these inputs. Every result, including the new status, the exception pulse, the vector index, the link value and the PC load request for trap return, is registered and is visible one clock later. Enabling and disabling interrupts are separate operations, and neither carries a data value.

Top module: `exc_window_ctrl`

## Requirements
- R1: After reset the flags, the interrupt-enable bit, the priority field and the saved status are all zero. The window pointer equals parameter RESET_CWP (default 8), and exc_o and pc_load_o are low.
- R2: The status word is laid out as {ipri[5:0], ie, cwp[CWP_W-1:0], N, V, Z, C}, with C at bit 0 and N at bit 3. When flags_we_i is high, flags_i is written to the flags, unless the cycle takes an exception or performs a trap return.
- R3: If irq_i is high while ie is 1 and the current operation raises no exception, an interrupt is taken with vector irq_num_i. The operation in that cycle is discarded, and the link value is pc_i>>1.
- R4: While ie is 0, irq_i has no effect.
- R5: Op code 3 (software trap) is taken whatever the value of ie. Its vector is trap_num_i and its link value is (pc_i+2)>>1.
- R6: One cycle after an exception is taken: exc_o pulses high, the saved status holds the status from before the exception, ie is 0, the window pointer is one below its old value, and the priority field and vec_o equal the exception number.
- R7: Op code 1 (save) decrements the window pointer. If the old pointer equals lo_limit_i while ie is 1, exception 1 is taken and the pointer is decremented only once, to lo_limit_i-1. The link value is (pc_i+2)>>1.
- R8: Op code 2 (restore) increments the window pointer. If the old pointer equals hi_limit_i while ie is 1, exception 2 is taken. The increment is dropped and the pointer becomes hi_limit_i-1. The link value is (pc_i+2)>>1.
- R9: An exception raised by the current operation wins over a pending external interrupt in the same cycle.
- R10: Op code 4 (trap return) raises pc_load_o for one cycle with pc_o = ret_addr_i<<1. It copies the saved status back into the status word, including the window pointer.
- R11: Op code 5 clears ie and op code 6 sets ie. Op codes 0 and 7 do nothing.
- R12: While ie is 0, a save or restore at a limit moves the pointer without any exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code of the current instruction |
| trap_num_i | input | 6 | Software trap number |
| irq_i | input | 1 | External interrupt request |
| irq_num_i | input | 6 | External interrupt number |
| pc_i | input | PC_W | Address of the current instruction |
| ret_addr_i | input | PC_W | Register value used by trap return |
| flags_we_i | input | 1 | Condition flag write enable |
| flags_i | input | 4 | New condition flags {N,V,Z,C} |
| lo_limit_i | input | CWP_W | Lower window limit |
| hi_limit_i | input | CWP_W | Upper window limit |
| status_o | output | CWP_W+11 | Status word |
| istatus_o | output | CWP_W+11 | Saved status word |
| cwp_o | output | CWP_W | Current window pointer |
| ie_o | output | 1 | Interrupt enable |
| ipri_o | output | 6 | Priority field |
| exc_o | output | 1 | Exception taken, one-cycle pulse |
| vec_o | output | 6 | Vector index of the last exception |
| link_o | output | PC_W | Link register value of the last exception |
| pc_load_o | output | 1 | Trap return PC load, one-cycle pulse |
| pc_o | output | PC_W | Trap return target |

## Verification
Every result appears exactly one clock after the operation that causes it. This covers the status fields, the saved status, the exception pulse with its vector and link value, and the trap-return PC load. The bench drives each operation on a falling edge and advances its behavioural model by one step. It then compares every output on the next falling edge, after the single register stage has updated. Because of this one-cycle spacing, a window trap, an interrupt that loses priority and a blocked request can each be checked in the cycle that follows it, and a stale or early value is caught.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_W = 6;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_SAVE    = 3'd1,
    OP_RESTORE = 3'd2,
    OP_TRAP    = 3'd3,
    OP_TRET    = 3'd4,
    OP_CLR_IE  = 3'd5,
    OP_SET_IE  = 3'd6,
    OP_RSVD    = 3'd7
  } op_e;

  localparam logic [NUM_W-1:0] VEC_SAVE_OVF = NUM_W'(1);
  localparam logic [NUM_W-1:0] VEC_REST_OVF = NUM_W'(2);
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter import exc_pkg::*; #(
  parameter int CWP_W = 5,
  parameter int PC_W  = 32
) (
  input  op_e              op_i,
  input  logic             ie_i,
  input  logic             irq_i,
  input  logic [NUM_W-1:0] irq_num_i,
  input  logic [NUM_W-1:0] trap_num_i,
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [CWP_W-1:0] lo_limit_i,
  input  logic [CWP_W-1:0] hi_limit_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic             take_o,
  output logic [NUM_W-1:0] num_o,
  output logic [PC_W-1:0]  link_o
);
  logic save_ovf, rest_ovf, sw_trap, op_exc, irq_take;

  assign save_ovf = (op_i == OP_SAVE)    && (cwp_i == lo_limit_i) && ie_i;
  assign rest_ovf = (op_i == OP_RESTORE) && (cwp_i == hi_limit_i) && ie_i;
  assign sw_trap  = (op_i == OP_TRAP);
  assign op_exc   = save_ovf | rest_ovf | sw_trap;
  // instruction-raised exceptions outrank the external request
  assign irq_take = irq_i && ie_i && !op_exc;
  assign take_o   = op_exc | irq_take;

  always_comb begin
    if (save_ovf)      num_o = VEC_SAVE_OVF;
    else if (rest_ovf) num_o = VEC_REST_OVF;
    else if (sw_trap)  num_o = trap_num_i;
    else               num_o = irq_num_i;
  end

  // interrupt preempts the current instruction; others resume after it
  assign link_o = op_exc ? ((pc_i + PC_W'(2)) >> 1) : (pc_i >> 1);
endmodule

// File: rtl/cwp_unit.sv
module cwp_unit import exc_pkg::*; #(
  parameter int CWP_W     = 5,
  parameter int RESET_CWP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  op_e              op_i,
  input  logic             load_i,
  input  logic [CWP_W-1:0] load_val_i,
  output logic [CWP_W-1:0] cwp_o
);
  logic [CWP_W-1:0] cwp_q, cwp_d;

  always_comb begin
    cwp_d = cwp_q;
    if (take_i)                   cwp_d = cwp_q - 1'b1;
    else if (load_i)              cwp_d = load_val_i;
    else if (op_i == OP_SAVE)     cwp_d = cwp_q - 1'b1;
    else if (op_i == OP_RESTORE)  cwp_d = cwp_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cwp_q <= CWP_W'(RESET_CWP);
    else         cwp_q <= cwp_d;
  end

  assign cwp_o = cwp_q;
endmodule

// File: rtl/exc_window_ctrl.sv
module exc_window_ctrl import exc_pkg::*; #(
  parameter int CWP_W     = 5,
  parameter int PC_W      = 32,
  parameter int RESET_CWP = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [2:0]                op_i,
  input  logic [NUM_W-1:0]          trap_num_i,
  input  logic                      irq_i,
  input  logic [NUM_W-1:0]          irq_num_i,
  input  logic [PC_W-1:0]           pc_i,
  input  logic [PC_W-1:0]           ret_addr_i,
  input  logic                      flags_we_i,
  input  logic [3:0]                flags_i,
  input  logic [CWP_W-1:0]          lo_limit_i,
  input  logic [CWP_W-1:0]          hi_limit_i,
  output logic [CWP_W+NUM_W+4:0]    status_o,
  output logic [CWP_W+NUM_W+4:0]    istatus_o,
  output logic [CWP_W-1:0]          cwp_o,
  output logic                      ie_o,
  output logic [NUM_W-1:0]          ipri_o,
  output logic                      exc_o,
  output logic [NUM_W-1:0]          vec_o,
  output logic [PC_W-1:0]           link_o,
  output logic                      pc_load_o,
  output logic [PC_W-1:0]           pc_o
);
  localparam int ST_W     = CWP_W + NUM_W + 5;
  localparam int CWP_LSB  = 4;
  localparam int IE_BIT   = 4 + CWP_W;
  localparam int IPRI_LSB = 5 + CWP_W;

  op_e              op;
  logic             take;
  logic [NUM_W-1:0] num;
  logic [PC_W-1:0]  link;
  logic             tret;
  logic [CWP_W-1:0] cwp;

  logic [3:0]       flags_q;
  logic             ie_q;
  logic [NUM_W-1:0] ipri_q;
  logic [ST_W-1:0]  ist_q;
  logic [ST_W-1:0]  status;
  logic             exc_q, pcl_q;
  logic [NUM_W-1:0] vec_q;
  logic [PC_W-1:0]  link_q, pc_q;

  assign op     = op_e'(op_i);
  assign status = {ipri_q, ie_q, cwp, flags_q};
  assign tret   = !take && (op == OP_TRET);

  exc_arbiter #(.CWP_W(CWP_W), .PC_W(PC_W)) u_arb (
    .op_i       (op),
    .ie_i       (ie_q),
    .irq_i      (irq_i),
    .irq_num_i  (irq_num_i),
    .trap_num_i (trap_num_i),
    .cwp_i      (cwp),
    .lo_limit_i (lo_limit_i),
    .hi_limit_i (hi_limit_i),
    .pc_i       (pc_i),
    .take_o     (take),
    .num_o      (num),
    .link_o     (link)
  );

  cwp_unit #(.CWP_W(CWP_W), .RESET_CWP(RESET_CWP)) u_cwp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .op_i       (op),
    .load_i     (tret),
    .load_val_i (ist_q[CWP_LSB +: CWP_W]),
    .cwp_o      (cwp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      ie_q    <= 1'b0;
      ipri_q  <= '0;
      ist_q   <= '0;
      exc_q   <= 1'b0;
      vec_q   <= '0;
      link_q  <= '0;
      pcl_q   <= 1'b0;
      pc_q    <= '0;
    end else begin
      exc_q <= take;
      pcl_q <= tret;
      if (take) begin
        ist_q  <= status;
        ie_q   <= 1'b0;
        ipri_q <= num;
        vec_q  <= num;
        link_q <= link;
      end else if (tret) begin
        flags_q <= ist_q[3:0];
        ie_q    <= ist_q[IE_BIT];
        ipri_q  <= ist_q[IPRI_LSB +: NUM_W];
        pc_q    <= {ret_addr_i[PC_W-2:0], 1'b0};
      end else begin
        if (flags_we_i) flags_q <= flags_i;
        if (op == OP_CLR_IE) ie_q <= 1'b0;
        else if (op == OP_SET_IE) ie_q <= 1'b1;
      end
    end
  end

  assign status_o  = status;
  assign istatus_o = ist_q;
  assign cwp_o     = cwp;
  assign ie_o      = ie_q;
  assign ipri_o    = ipri_q;
  assign exc_o     = exc_q;
  assign vec_o     = vec_q;
  assign link_o    = link_q;
  assign pc_load_o = pcl_q;
  assign pc_o      = pc_q;
endmodule

// File: rtl/exc_window_ctrl_chk.sv
module exc_window_ctrl_chk import exc_pkg::*; #(
  parameter int CWP_W = 5,
  parameter int PC_W  = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [2:0]             op_i,
  input logic [NUM_W-1:0]       trap_num_i,
  input logic                   irq_i,
  input logic [CWP_W-1:0]       lo_limit_i,
  input logic [CWP_W+NUM_W+4:0] status_o,
  input logic [CWP_W+NUM_W+4:0] istatus_o,
  input logic [CWP_W-1:0]       cwp_o,
  input logic                   ie_o,
  input logic                   exc_o,
  input logic [NUM_W-1:0]       vec_o,
  input logic                   pc_load_o
);
  // R6
  entry_cwp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> cwp_o == CWP_W'($past(cwp_o) - 1'b1));

  // R6
  entry_ist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> istatus_o == $past(status_o));

  // R11
  clr_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CLR_IE) |=> !ie_o);

  // R4
  irq_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !ie_o && op_i == OP_NONE) |=> !exc_o);

  // R7
  save_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SAVE && cwp_o == lo_limit_i && ie_o)
      |=> exc_o && vec_o == VEC_SAVE_OVF && cwp_o == CWP_W'($past(lo_limit_i) - 1'b1));

  // R5
  sw_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_TRAP) |=> exc_o && vec_o == $past(trap_num_i));

  // R10
  tret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_TRET && !(irq_i && ie_o)) |=> pc_load_o && status_o == $past(istatus_o));
endmodule

bind exc_window_ctrl exc_window_ctrl_chk #(.CWP_W(CWP_W), .PC_W(PC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .trap_num_i (trap_num_i),
  .irq_i      (irq_i),
  .lo_limit_i (lo_limit_i),
  .status_o   (status_o),
  .istatus_o  (istatus_o),
  .cwp_o      (cwp_o),
  .ie_o       (ie_o),
  .exc_o      (exc_o),
  .vec_o      (vec_o),
  .pc_load_o  (pc_load_o)
);

// File: tb/tb_exc_window_ctrl.sv
`timescale 1ns/1ps
module tb_exc_window_ctrl;
  localparam int CW = 5;
  localparam int PW = 32;
  localparam int SW = CW + 11;
  localparam int CMASK = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic [5:0] trap_num = '0, irq_num = '0;
  logic irq = 1'b0, fwe = 1'b0;
  logic [PW-1:0] pc = '0, ret = '0;
  logic [3:0] fl = '0;
  logic [CW-1:0] lo = CW'(2), hi = CW'(12);
  logic [SW-1:0] status, istatus;
  logic [CW-1:0] cwp;
  logic ie, exc, pcl;
  logic [5:0] ipri, vec;
  logic [PW-1:0] link, pco;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_flags = 0, m_ie = 0, m_cwp = 8, m_ipri = 0, m_ist = 0;
  int m_exc = 0, m_vec = 0, m_pcl = 0;
  logic [PW-1:0] m_link = '0, m_pc = '0;

  always #2.5 clk = ~clk;

  exc_window_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .trap_num_i(trap_num),
    .irq_i(irq), .irq_num_i(irq_num), .pc_i(pc), .ret_addr_i(ret),
    .flags_we_i(fwe), .flags_i(fl), .lo_limit_i(lo), .hi_limit_i(hi),
    .status_o(status), .istatus_o(istatus), .cwp_o(cwp), .ie_o(ie),
    .ipri_o(ipri), .exc_o(exc), .vec_o(vec), .link_o(link),
    .pc_load_o(pcl), .pc_o(pco)
  );

  function automatic int pack();
    return (m_ipri << (CW + 5)) | (m_ie << (CW + 4)) | (m_cwp << 4) | m_flags;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "status",  status,  pack());
    chk(tag, "istatus", istatus, m_ist);
    chk(tag, "cwp",     cwp,     m_cwp);
    chk(tag, "ie",      ie,      m_ie);
    chk(tag, "ipri",    ipri,    m_ipri);
    chk(tag, "exc",     exc,     m_exc);
    chk(tag, "vec",     vec,     m_vec);
    chk(tag, "link",    link,    m_link);
    chk(tag, "pc_load", pcl,     m_pcl);
    chk(tag, "pc",      pco,     m_pc);
  endtask

  task automatic step(input string tag, input int o, input bit rq = 0, input int inum = 0,
                      input int tnum = 0, input logic [PW-1:0] p = 32'h100,
                      input logic [PW-1:0] r = 32'h0, input bit fw = 0, input int f = 0);
    bit sov, rov, sw, opx, itk;
    int num;
    op = 3'(o); irq = rq; irq_num = 6'(inum); trap_num = 6'(tnum);
    pc = p; ret = r; fwe = fw; fl = 4'(f);
    sov = (o == 1) && (m_cwp == int'(lo)) && (m_ie == 1);
    rov = (o == 2) && (m_cwp == int'(hi)) && (m_ie == 1);
    sw  = (o == 3);
    opx = sov || rov || sw;
    itk = rq && (m_ie == 1) && !opx;
    m_pcl = 0;
    if (opx || itk) begin
      num = sov ? 1 : rov ? 2 : sw ? tnum : inum;
      m_ist = pack();
      m_ie = 0;
      m_cwp = (m_cwp - 1) & CMASK;
      m_ipri = num;
      m_exc = 1;
      m_vec = num;
      m_link = opx ? (p + 2) >> 1 : p >> 1;
    end else begin
      m_exc = 0;
      if (o == 4) begin
        m_pcl = 1;
        m_pc = r << 1;
        m_flags = m_ist & 15;
        m_cwp = (m_ist >> 4) & CMASK;
        m_ie = (m_ist >> (CW + 4)) & 1;
        m_ipri = (m_ist >> (CW + 5)) & 63;
      end else begin
        if (fw) m_flags = f;
        case (o)
          1: m_cwp = (m_cwp - 1) & CMASK;
          2: m_cwp = (m_cwp + 1) & CMASK;
          5: m_ie = 0;
          6: m_ie = 1;
          default: ;
        endcase
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    step("R2", 0, .fw(1), .f(4'b1010));
    step("R4", 0, .rq(1), .inum(9));
    step("R4", 1, .rq(1), .inum(9));                 // cwp 8->7, no interrupt
    step("R11", 6);
    step("R11", 5);
    step("R11", 7);
    step("R11", 6);
    step("R3", 1, .rq(1), .inum(17), .p(32'h240));   // save discarded
    step("R6", 0);
    step("R10", 4, .r(32'h1234));
    step("R5", 3, .tnum(33), .p(32'h400), .fw(1), .f(4'h5));
    step("R10", 4, .r(32'h0800_0001));
    step("R5", 5);
    step("R5", 3, .tnum(7), .p(32'h502));
    step("R10", 4, .r(32'h40));
    step("R11", 6);
    for (int i = 0; i < 5; i++) step("R7", 1);
    step("R9", 1, .rq(1), .inum(40), .p(32'h610));   // window trap 1 wins
    step("R7", 0, .rq(1), .inum(40));
    step("R10", 4, .r(32'h22));
    for (int i = 0; i < 10; i++) step("R8", 2);
    step("R8", 2, .rq(1), .inum(41), .p(32'h700));
    step("R10", 4, .r(32'h99));
    step("R9", 3, .rq(1), .inum(50), .tnum(12), .p(32'h800));
    step("R10", 4, .r(32'h5));
    step("R12", 5);
    step("R12", 2);                                   // at hi, ie=0
    lo = CW'(13);
    step("R12", 1);                                   // at lo, ie=0
    step("R2", 0, .fw(1), .f(4'hF));
    step("R3", 6);
    step("R3", 2, .rq(1), .inum(63), .p(32'hFFFF_FFFE));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule